// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load pulse takes a full start address from the external bus. The two lowest bits of that address become the first burst offset. The upper bits are held unchanged for the rest of the burst. Each later advance pulse moves the offset to the next beat. After the fourth beat the offset returns to the loaded start value.

A mode input chooses one of two orders. With the mode input low, the order is linear: the offset counts up by one, modulo four. With it high, the order is interleaved: the offset is the start value XOR the beat number. The mode input is a static strap, held high or low, and never changed during a burst. The caller decodes its own strobes into the load and advance pulses. This block only keeps the position within the burst.

Inside, a small state machine has two states. `ST_EMPTY` means no burst has been loaded since reset. `ST_BURST` means a start address is held. There are four transitions:
- `ST_EMPTY` to `ST_BURST` on a load.
- `ST_BURST` to `ST_BURST` with a restart on a load.
- `ST_BURST` to `ST_BURST` with a step on an advance.
- `ST_BURST` to `ST_BURST` with a hold when neither pulse is present.

In `ST_EMPTY` an advance is ignored. A beat counter and the captured start value are kept apart, and the output offset is formed from the two.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addr_o` is all zeros, and advance pulses given before the first load leave it all zeros.
- R2: On a clock edge where `load_i` is high, the full `addr_i` is captured, and `addr_o` equals it after that edge.
- R3: With `mode_i` low, after k advances since the load, `addr_o[1:0]` equals (start + k) modulo 4.
- R4: With `mode_i` high, after k advances since the load, `addr_o[1:0]` equals start XOR (k modulo 4).
- R5: After the fourth advance the offset returns to the loaded start value, and further advances repeat the same four-value sequence.
- R6: On an edge with neither `load_i` nor `adv_i` high, `addr_o` stays unchanged.
- R7: On an edge where `load_i` and `adv_i` are both high, the advance is ignored: `addr_o` equals the new `addr_i`, and the next advance yields the beat-1 offset.
- R8: A load in the middle of a burst restarts the sequence at once from the new start value.
- R9: `addr_o[ADDR_W-1:2]` holds the upper bits captured at the load and does not change on advances, whatever `addr_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| load_i | input | 1 | Capture `addr_i` and start a burst at beat 0 |
| adv_i | input | 1 | Step to the next beat (ignored on a load edge and before the first load) |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address: held upper bits with the current offset |

## Verification
A load and an advance can be sampled on the same edge. The load must win, and the beat count must restart at zero. The bench provokes this in two ways. It raises both pulses together at the start of a burst. It also reloads in the middle of a burst while an advance is present. In each case it judges two things: that `addr_o` equals the new start address right after that edge, and that the next advance gives the beat-1 offset rather than beat 2.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFF_W = 2;
    localparam int BEATS = 1 << OFF_W;

    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    output burst_state_e state_o,
    output off_t         beat_o
);

    burst_state_e state_q, state_d;
    off_t         beat_q, beat_d;

    // next-state and beat update
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_i) begin
                    state_d = ST_BURST;
                    beat_d  = '0;
                end
            end
            ST_BURST: begin
                if (load_i) begin
                    beat_d = '0;
                end else if (adv_i) begin
                    beat_d = beat_q + off_t'(1);
                end
            end
            default: begin
                state_d = ST_EMPTY;
                beat_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_pkg::*;
(
    input  logic mode_i,
    input  off_t start_i,
    input  off_t beat_i,
    output off_t off_o
);

    off_t lin_off;
    off_t ilv_off;

    assign lin_off = start_i + beat_i;
    assign ilv_off = start_i ^ beat_i;

    always_comb begin
        off_o = mode_i ? ilv_off : lin_off;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - OFF_W;

    burst_state_e    state;
    off_t            beat;
    off_t            start_q;
    logic [UP_W-1:0] upper_q;
    off_t            off;

    burst_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .state_o (state),
        .beat_o  (beat)
    );

    // captured start address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            upper_q <= '0;
        end else if (load_i) begin
            start_q <= addr_i[OFF_W-1:0];
            upper_q <= addr_i[ADDR_W-1:OFF_W];
        end
    end

    burst_offset_map u_map (
        .mode_i  (mode_i),
        .start_i (start_q),
        .beat_i  (beat),
        .off_o   (off)
    );

    // output process
    always_comb begin
        unique case (state)
            ST_EMPTY: addr_o = '0;
            ST_BURST: addr_o = {upper_q, off};
            default:  addr_o = '0;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              load_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);

    logic loaded_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loaded_q <= 1'b0;
        else if (load_i) loaded_q <= 1'b1;
    end

    // R1
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_q |-> addr_o == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(addr_i));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && adv_i && !load_i && !mode_i) |=>
        (mode_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

    // R4
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && adv_i && !load_i && mode_i) |=>
        (!mode_i || addr_o[0] != $past(addr_o[0])));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> (addr_o == $past(addr_o) || mode_i != $past(mode_i)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && adv_i) |=> addr_o[1:0] == $past(addr_i[1:0]));

    // R9
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:2]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .addr_i (addr_i),
    .addr_o (addr_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .load_i (load_i),
        .adv_i  (adv_i),
        .addr_i (addr_i),
        .addr_o (addr_o)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (addr_o !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic av, input logic [AW-1:0] a);
        @(negedge clk);
        load_i = ld;
        adv_i  = av;
        addr_i = a;
        @(posedge clk);
        #1;
        load_i = 1'b0;
        adv_i  = 1'b0;
        addr_i = ~a;
    endtask

    function automatic logic [1:0] exp_off(input logic m, input logic [1:0] s, input int k);
        logic [1:0] kb;
        kb = 2'(k % 4);
        return m ? (s ^ kb) : (s + kb);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [5:0]    up;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 8'hFF);
        check("R1 adv before load", '0);
        drive(1'b0, 1'b1, 8'hA7);
        check("R1 adv before load", '0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                mode_i = m[0];
                up   = 6'(s * 13 + m * 29 + 5);
                base = {up, 2'(s)};
                drive(1'b1, 1'b0, base);
                check("R2 load", base);
                for (int k = 1; k <= 9; k++) begin
                    if (k == 3) begin
                        drive(1'b0, 1'b0, 8'h00);
                        check("R6 hold", {up, exp_off(m[0], 2'(s), 2)});
                    end
                    drive(1'b0, 1'b1, 8'h00);
                    if (k % 4 == 0)
                        check("R5 wrap", {up, 2'(s)});
                    else if (m == 0)
                        check("R3 linear R9 upper", {up, exp_off(1'b0, 2'(s), k)});
                    else
                        check("R4 interleaved R9 upper", {up, exp_off(1'b1, 2'(s), k)});
                end
            end
        end

        // load and advance on the same edge
        @(negedge clk);
        mode_i = 1'b0;
        drive(1'b1, 1'b1, 8'h5A);
        check("R7 load wins", 8'h5A);
        drive(1'b0, 1'b1, 8'h00);
        check("R7 next beat is 1", 8'h5B);

        // reload in mid burst, with an advance present
        @(negedge clk);
        mode_i = 1'b1;
        drive(1'b1, 1'b0, 8'h30);
        drive(1'b0, 1'b1, 8'h00);
        drive(1'b0, 1'b1, 8'h00);
        check("R4 mid", 8'h32);
        drive(1'b1, 1'b1, 8'hC3);
        check("R8 restart", 8'hC3);
        drive(1'b0, 1'b1, 8'h00);
        check("R8 restart step", 8'hC2);
        drive(1'b0, 1'b1, 8'h00);
        check("R8 restart step2", 8'hC1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule